// File: doc/BRIEF.md
# Load-Reserved Reservation Monitor

This block tracks address reservations for load-locked / store-conditional atomic sequences across a fixed number of hardware contexts. Each context holds at most one reservation. A reservation is a single granule-aligned address that the context has load-locked. The block sits beside a memory and is told about two things: every load-locked request and every write that reaches the memory. A write can be an ordinary store or a conditional store.

Each write is compared, at reservation-granule resolution, with every live reservation. Any reservation whose granule matches is dropped, whichever context owns it and whether or not the write is allowed to commit. An ordinary store is always permitted. A conditional store is permitted only if its own context still holds a reservation on the written granule. The verdict is registered and returned one cycle after the write. It carries a commit bit, which the memory must honour, and a conditional-success bit, which goes back to the requester as 1 for success and 0 for failure.

Top module: `resv_monitor`

## Requirements
- R1: After reset no context holds a reservation. A conditional store from a context with no live reservation is refused: commit 0 and success 0.
- R2: A load-locked followed by a conditional store from the same context to the same granule is accepted: commit 1 and success 1.
- R3: Addresses are compared with their low GRAN_LG bits dropped. A conditional store at another offset inside the reserved granule succeeds. One in a different granule fails.
- R4: A second load-locked from a context replaces that context's reservation. A conditional store to the old granule then fails and one to the new granule succeeds.
- R5: A conditional store from another context to a reserved granule fails. It still removes the owner's reservation, so the owner's later conditional store there fails.
- R6: An ordinary store always returns commit 1 and success 0. It removes the reservations of all contexts on its granule.
- R7: A write to a different granule leaves an existing reservation intact.
- R8: Every conditional store removes the reservations on its granule, including a successful one. A repeated conditional store therefore fails.
- R9: When a load-locked and a write to the same granule arrive in the same cycle, the write's removal is applied first and the new reservation survives.
- R10: rsp_valid_o is high exactly in the cycle after each cycle with wr_valid_i high, and low otherwise. Back-to-back writes give back-to-back responses.
- R11: Reservations held by different contexts on different granules are independent of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ll_valid_i | input | 1 | Load-locked request pulse |
| ll_ctx_i | input | CTX_W | Context issuing the load-locked |
| ll_addr_i | input | ADDR_W | Load-locked byte address |
| wr_valid_i | input | 1 | Write request pulse |
| wr_ctx_i | input | CTX_W | Context issuing the write |
| wr_addr_i | input | ADDR_W | Write byte address |
| wr_cond_i | input | 1 | 1 = conditional store, 0 = ordinary store |
| rsp_valid_o | output | 1 | Verdict strobe, one cycle after the write |
| rsp_commit_o | output | 1 | Memory may be updated by this write |
| rsp_sc_ok_o | output | 1 | Conditional-store result: 1 success, 0 failure |

## Verification
The hardest case to reach from the ports is a reservation that is removed by a third party. The state is visible only through the outcome of a later conditional store, and that store consumes the reservation itself. The stimulus therefore builds each scenario on fresh granules. It has one context reserve, another context store (ordinary or conditional), and the owner then probe with a conditional store. For the same-cycle case, a load-locked and a write to the same granule are driven on one clock edge, and a probe follows.

// File: rtl/resv_pkg.sv
package resv_pkg;
  typedef struct packed {
    logic valid;
    logic commit;
    logic sc_ok;
  } resv_rsp_t;
endpackage

// File: rtl/resv_entry.sv
module resv_entry #(
  parameter int GW = 29
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          alloc_i,
  input  logic [GW-1:0] alloc_gran_i,
  input  logic          wr_valid_i,
  input  logic [GW-1:0] wr_gran_i,
  output logic          valid_o,
  output logic          hit_o
);
  logic [GW-1:0] gran_q;
  logic          valid_q;

  assign hit_o   = valid_q && (gran_q == wr_gran_i);
  assign valid_o = valid_q;

  // allocation wins over same-cycle invalidation
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      gran_q  <= '0;
    end else if (alloc_i) begin
      valid_q <= 1'b1;
      gran_q  <= alloc_gran_i;
    end else if (wr_valid_i && hit_o) begin
      valid_q <= 1'b0;
    end
  end
endmodule

// File: rtl/resv_rsp.sv
module resv_rsp
  import resv_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  resv_rsp_t rsp_d,
  output resv_rsp_t rsp_q
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rsp_q <= '0;
    else         rsp_q <= rsp_d;
  end
endmodule

// File: rtl/resv_monitor.sv
module resv_monitor
  import resv_pkg::*;
#(
  parameter int N_CTX   = 4,
  parameter int ADDR_W  = 32,
  parameter int GRAN_LG = 3,
  localparam int CTX_W  = (N_CTX > 1) ? $clog2(N_CTX) : 1,
  localparam int GW     = ADDR_W - GRAN_LG
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ll_valid_i,
  input  logic [CTX_W-1:0]  ll_ctx_i,
  input  logic [ADDR_W-1:0] ll_addr_i,
  input  logic              wr_valid_i,
  input  logic [CTX_W-1:0]  wr_ctx_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic              wr_cond_i,
  output logic              rsp_valid_o,
  output logic              rsp_commit_o,
  output logic              rsp_sc_ok_o
);
  logic [GW-1:0]    ll_gran, wr_gran;
  logic [N_CTX-1:0] valid_q, wr_hit, own_sel;
  logic             own_hit, success;
  resv_rsp_t        rsp_d, rsp_q;

  assign ll_gran = ll_addr_i[ADDR_W-1:GRAN_LG];
  assign wr_gran = wr_addr_i[ADDR_W-1:GRAN_LG];

  for (genvar i = 0; i < N_CTX; i++) begin : g_ent
    resv_entry #(.GW(GW)) u_ent (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .alloc_i     (ll_valid_i && (ll_ctx_i == CTX_W'(i))),
      .alloc_gran_i(ll_gran),
      .wr_valid_i  (wr_valid_i),
      .wr_gran_i   (wr_gran),
      .valid_o     (valid_q[i]),
      .hit_o       (wr_hit[i])
    );
    assign own_sel[i] = wr_hit[i] && (wr_ctx_i == CTX_W'(i));
  end

  assign own_hit = |own_sel;
  assign success = !wr_cond_i || own_hit;

  always_comb begin
    rsp_d.valid  = wr_valid_i;
    rsp_d.commit = wr_valid_i && success;
    rsp_d.sc_ok  = wr_valid_i && wr_cond_i && own_hit;
  end

  resv_rsp u_rsp (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rsp_d (rsp_d),
    .rsp_q (rsp_q)
  );

  assign rsp_valid_o  = rsp_q.valid;
  assign rsp_commit_o = rsp_q.commit;
  assign rsp_sc_ok_o  = rsp_q.sc_ok;
endmodule

// File: rtl/resv_monitor_chk.sv
module resv_monitor_chk #(
  parameter int N_CTX = 4,
  parameter int CTX_W = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ll_valid_i,
  input logic [CTX_W-1:0] ll_ctx_i,
  input logic             wr_valid_i,
  input logic [CTX_W-1:0] wr_ctx_i,
  input logic             wr_cond_i,
  input logic [N_CTX-1:0] valid_q,
  input logic [N_CTX-1:0] wr_hit,
  input logic             rsp_valid_o,
  input logic             rsp_commit_o,
  input logic             rsp_sc_ok_o
);
  a_r10_rsp_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_i |=> rsp_valid_o);
  a_r10_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_valid_i |=> !rsp_valid_o);
  a_r6_plain_commits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && !wr_cond_i) |=> (rsp_commit_o && !rsp_sc_ok_o));
  a_r8_sc_ok_is_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && wr_cond_i) |=> (rsp_sc_ok_o == rsp_commit_o));
  a_r1_no_resv_fails: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && wr_cond_i && !valid_q[wr_ctx_i]) |=> !rsp_commit_o);
  a_r9_ll_survives: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ll_valid_i |=> valid_q[$past(ll_ctx_i)]);
  a_r5_write_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && !ll_valid_i) |=> ((valid_q & $past(wr_hit)) == '0));
endmodule

bind resv_monitor resv_monitor_chk #(.N_CTX(N_CTX), .CTX_W(CTX_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ll_valid_i  (ll_valid_i),
  .ll_ctx_i    (ll_ctx_i),
  .wr_valid_i  (wr_valid_i),
  .wr_ctx_i    (wr_ctx_i),
  .wr_cond_i   (wr_cond_i),
  .valid_q     (valid_q),
  .wr_hit      (wr_hit),
  .rsp_valid_o (rsp_valid_o),
  .rsp_commit_o(rsp_commit_o),
  .rsp_sc_ok_o (rsp_sc_ok_o)
);

// File: tb/sim_resv_monitor.sv
`timescale 1ns/1ps
module sim_resv_monitor;
  localparam int N_CTX = 4;
  localparam int ADDR_W = 32;
  localparam int CTX_W = 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic ll_valid_i = 1'b0, wr_valid_i = 1'b0, wr_cond_i = 1'b0;
  logic [CTX_W-1:0] ll_ctx_i = '0, wr_ctx_i = '0;
  logic [ADDR_W-1:0] ll_addr_i = '0, wr_addr_i = '0;
  logic rsp_valid_o, rsp_commit_o, rsp_sc_ok_o;

  int total = 0, bad = 0;
  bit done = 1'b0;
  logic [1:0] exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  resv_monitor #(.N_CTX(N_CTX), .ADDR_W(ADDR_W), .GRAN_LG(3)) u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .ll_valid_i(ll_valid_i), .ll_ctx_i(ll_ctx_i), .ll_addr_i(ll_addr_i),
    .wr_valid_i(wr_valid_i), .wr_ctx_i(wr_ctx_i), .wr_addr_i(wr_addr_i),
    .wr_cond_i(wr_cond_i),
    .rsp_valid_o(rsp_valid_o), .rsp_commit_o(rsp_commit_o), .rsp_sc_ok_o(rsp_sc_ok_o)
  );

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // monitor: pop expected verdicts as responses appear
  always @(posedge clk) begin
    #2;
    if (rst_ni && rsp_valid_o) begin
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL R10 unexpected response: got valid=1 expected valid=0");
      end else begin
        logic [1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if ({rsp_commit_o, rsp_sc_ok_o} !== e) begin
          bad++;
          $display("FAIL %s commit/sc_ok got %b%b expected %b", t, rsp_commit_o, rsp_sc_ok_o, e);
        end
      end
    end else if (rst_ni && exp_q.size() != 0) begin
      total++; bad++;
      $display("FAIL R10 missing response: got valid=0 expected valid=1");
      void'(exp_q.pop_front());
      void'(tag_q.pop_front());
    end
  end

  task automatic ll(input int ctx, input logic [ADDR_W-1:0] a);
    @(negedge clk);
    ll_valid_i = 1'b1; ll_ctx_i = CTX_W'(ctx); ll_addr_i = a;
    @(posedge clk); #1;
    ll_valid_i = 1'b0;
  endtask

  task automatic wr(input int ctx, input logic [ADDR_W-1:0] a, input logic cond,
                    input logic ok, input string tag);
    @(negedge clk);
    wr_valid_i = 1'b1; wr_ctx_i = CTX_W'(ctx); wr_addr_i = a; wr_cond_i = cond;
    exp_q.push_back({ok, cond & ok});
    tag_q.push_back(tag);
    @(posedge clk); #1;
    wr_valid_i = 1'b0;
  endtask

  task automatic ll_wr(input int lctx, input int wctx, input logic [ADDR_W-1:0] a);
    @(negedge clk);
    ll_valid_i = 1'b1; ll_ctx_i = CTX_W'(lctx); ll_addr_i = a;
    wr_valid_i = 1'b1; wr_ctx_i = CTX_W'(wctx); wr_addr_i = a; wr_cond_i = 1'b0;
    exp_q.push_back(2'b10);
    tag_q.push_back("R9");
    @(posedge clk); #1;
    ll_valid_i = 1'b0; wr_valid_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    total++;
    if (rsp_valid_o !== 1'b0 || rsp_commit_o !== 1'b0) begin
      bad++;
      $display("FAIL R1 reset outputs got %b%b expected 00", rsp_valid_o, rsp_commit_o);
    end
    rst_ni = 1'b1;
    // R1: nothing reserved after reset
    wr(0, 32'h100, 1, 0, "R1");
    wr(3, 32'h100, 1, 0, "R1");
    // R2 then R8
    ll(1, 32'h200);
    wr(1, 32'h200, 1, 1, "R2");
    wr(1, 32'h200, 1, 0, "R8");
    // R3 granule masking, R7 other granule keeps reservation
    ll(2, 32'h300);
    wr(2, 32'h305, 1, 1, "R3");
    ll(2, 32'h300);
    wr(2, 32'h308, 1, 0, "R3");
    wr(2, 32'h300, 1, 1, "R7");
    // R4 replacement
    ll(0, 32'h400);
    ll(0, 32'h500);
    wr(0, 32'h400, 1, 0, "R4");
    wr(0, 32'h500, 1, 1, "R4");
    // R5 foreign SC fails and clears
    ll(1, 32'h600);
    wr(3, 32'h600, 1, 0, "R5");
    wr(1, 32'h600, 1, 0, "R5");
    // R6 plain store commits and clears all contexts
    ll(0, 32'h700);
    ll(1, 32'h704);
    wr(2, 32'h700, 0, 1, "R6");
    wr(0, 32'h700, 1, 0, "R6");
    wr(1, 32'h700, 1, 0, "R6");
    // R11 independent contexts
    ll(2, 32'h800);
    ll(3, 32'h900);
    wr(3, 32'h900, 1, 1, "R11");
    wr(2, 32'h800, 1, 1, "R11");
    // R9 same-cycle reserve and write
    ll_wr(3, 0, 32'hA00);
    wr(3, 32'hA00, 1, 1, "R9");
    // R10 back-to-back responses then idle
    wr(0, 32'hB00, 0, 1, "R10");
    wr(1, 32'hB08, 0, 1, "R10");
    wr(2, 32'hB10, 1, 0, "R10");
    repeat (5) @(negedge clk);
    total++;
    if (exp_q.size() != 0) begin
      bad++;
      $display("FAIL R10 pending responses got %0d expected 0", exp_q.size());
    end
    finish_up();
  end

  initial begin
    #100000;
    total++; bad++;
    $display("FAIL watchdog expired got running expected done");
    finish_up();
  end
endmodule